// File: doc/BRIEF.md
# Packet Stream Scrambler with Self-Advancing LFSR Key

The block keeps a 32-bit linear feedback shift register as a running key and uses it to mask a byte stream one packet at a time. Each byte is XORed with one byte lane of the key, with the lane chosen by the byte's position in the packet modulo four. Outgoing command packets are scrambled and incoming response packets are descrambled. The two directions differ only in the first byte of a command, where two fixed bit positions are left unmasked.

The key stays fixed for the whole of a packet. When the last byte of a packet is accepted, the key advances by a number of register steps taken from its own low five bits. It takes one step per clock, and the input is held off while the advance runs. A synchronous clear returns the key to zero for reseeding. A zero key stays zero under stepping, so the mask is then transparent. A load port writes a new 32-bit key. Clear and load both cut short an advance that is in progress.

Top module: `pkt_scrambler`

## Requirements
- R1: One key step makes the new key equal to {k[0]^k[1]^k[21]^k[31], k[31:1]}, where k is the old key.
- R2: When a byte with end-of-packet set is accepted, the block is busy for exactly k[4:0]+35 cycles, using k as it stood at that moment. During that time it applies one step per cycle, and the advanced key then masks the next packet.
- R3: Byte position i of a packet (position 0 is the byte accepted with in_sop=1) is XORed with key bits [8*(i mod 4)+7 : 8*(i mod 4)].
- R4: With in_dir=1 (scramble), bits 3 and 5 (mask 0x28) of byte 0 pass through unchanged. All its other bits, and every later byte, are fully XORed.
- R5: With in_dir=0 (descramble), every byte is fully XORed, byte 0 included.
- R6: The key does not change while a packet is being accepted. The advance begins only after the end-of-packet byte.
- R7: key_clr sets the key to zero and ends any advance. Packets sent after that, with no load in between, pass through unchanged.
- R8: key_load writes key_value into the key and ends any advance. key_clr takes priority when both are asserted.
- R9: in_ready is low exactly while busy is high. Bytes offered during that time produce no output.
- R10: Each accepted byte appears on out_data one cycle later with out_valid=1, together with its sop and eop flags. In any other cycle out_valid is 0.
- R11: After reset the key is zero, busy is 0, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_clr | input | 1 | Synchronous clear of the key (reseed) |
| key_load | input | 1 | Load key_value into the key |
| key_value | input | 32 | New key value |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_dir | input | 1 | 1 = scramble, 0 = descramble; sampled per byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Masked byte |
| out_sop | output | 1 | Forwarded start-of-packet flag |
| out_eop | output | 1 | Forwarded end-of-packet flag |
| busy | output | 1 | Key advance in progress |

## Verification
The assertions take for granted that key_clr and key_load are single-cycle controls. They also assume that, once the upstream logic sees in_ready low, it does not count a byte as accepted. The stepping property therefore checks only the cycles in which neither control is asserted. The bench pulses clear and load only between packets, and once directly after an end-of-packet byte to cut short an advance. It gives every packet a fixed direction and a first byte marked with in_sop. It then checks each output byte, and the length of each busy window, against a key model that it advances itself.

// File: rtl/pkt_scr_pkg.sv
// Shared parameters and the key step function for the packet scrambler.
// Assumes a key width that is a whole number of bytes and a power-of-two
// lane count.
package pkt_scr_pkg;
    localparam int KEY_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int TAP_MID   = 21;
    localparam int SEL_BITS  = 5;
    localparam int BASE_STEP = 35;
    localparam logic [BYTE_W-1:0] KEEP_MASK = 8'h28;

    // One key step: shift right, feedback into the top bit.
    function automatic logic [KEY_W-1:0] key_step(input logic [KEY_W-1:0] k);
        return {k[0] ^ k[1] ^ k[TAP_MID] ^ k[KEY_W-1], k[KEY_W-1:1]};
    endfunction
endpackage

// File: rtl/scr_key_core.sv
// Key register with a self-timed advance. An advance starts on 'start' and
// runs sel+BASE steps, one per clock. Clear beats load, and both beat an
// advance. Assumes 'start' is only raised while not busy.
module scr_key_core
    import pkt_scr_pkg::*;
#(
    parameter int W    = KEY_W,
    parameter int SEL  = SEL_BITS,
    parameter int BASE = BASE_STEP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         start,
    output logic [W-1:0] key,
    output logic         busy
);
    localparam int RW = $clog2((1 << SEL) + BASE + 1);

    logic [RW-1:0] remain;

    // Key, busy flag and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key    <= '0;
            busy   <= 1'b0;
            remain <= '0;
        end else if (clr) begin
            key    <= '0;
            busy   <= 1'b0;
            remain <= '0;
        end else if (load) begin
            key    <= load_val;
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            key    <= key_step(key);
            remain <= remain - 1'b1;
            if (remain == RW'(1)) busy <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= RW'(key[SEL-1:0]) + RW'(BASE);
        end
    end
endmodule

// File: rtl/scr_byte_xform.sv
// Combinational byte mask: selects one key lane and XORs it into the byte.
// In scramble direction, byte 0 keeps the KEEP bits unmasked.
module scr_byte_xform
    import pkt_scr_pkg::*;
#(
    parameter int W  = KEY_W,
    parameter int BW = BYTE_W,
    parameter logic [BW-1:0] KEEP = KEEP_MASK,
    localparam int LANES = W / BW,
    localparam int LW    = $clog2(LANES)
) (
    input  logic [W-1:0]  key,
    input  logic [LW-1:0] lane,
    input  logic          first,
    input  logic          scramble,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] dout
);
    logic [BW-1:0] mask;
    logic [BW-1:0] keep;

    // Pick the lane and apply the pass-through bits.
    always_comb begin
        mask = key[lane*BW +: BW];
        keep = (first && scramble) ? KEEP : '0;
        dout = (din & keep) | ((din ^ mask) & ~keep);
    end
endmodule

// File: rtl/pkt_scrambler.sv
// Packet stream scrambler top. It accepts bytes when not busy, masks them
// with the current key and registers the result. An end-of-packet byte
// starts the key advance. Assumes every packet's first byte carries in_sop.
module pkt_scrambler
    import pkt_scr_pkg::*;
#(
    parameter int W  = KEY_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_clr,
    input  logic          key_load,
    input  logic [W-1:0]  key_value,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [BW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_dir,
    output logic          out_valid,
    output logic [BW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    output logic          busy
);
    localparam int LANES = W / BW;
    localparam int LW    = $clog2(LANES);

    logic [W-1:0]  key_q;
    logic [LW-1:0] lane_q;
    logic [LW-1:0] lane_cur;
    logic [BW-1:0] masked;
    logic          accept;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;
    assign lane_cur = in_sop ? '0 : lane_q;

    scr_key_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (key_clr),
        .load     (key_load),
        .load_val (key_value),
        .start    (accept && in_eop),
        .key      (key_q),
        .busy     (busy)
    );

    scr_byte_xform #(.W(W), .BW(BW)) u_xform (
        .key      (key_q),
        .lane     (lane_cur),
        .first    (in_sop),
        .scramble (in_dir),
        .din      (in_data),
        .dout     (masked)
    );

    // Byte position counter within a packet, modulo the lane count.
    always_ff @(posedge clk) begin
        if (!rst_n)      lane_q <= '0;
        else if (accept) lane_q <= lane_cur + 1'b1;
    end

    // Registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_data <= masked;
                out_sop  <= in_sop;
                out_eop  <= in_eop;
            end
        end
    end
endmodule

// File: rtl/pkt_scrambler_chk.sv
// Property checker for the packet scrambler, bound to the top module.
module pkt_scrambler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        key_clr,
    input logic        key_load,
    input logic [31:0] key_value,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_eop,
    input logic        out_valid,
    input logic        busy,
    input logic [31:0] key_q
);
    assert_step_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !key_clr && !key_load) |=> (key_q[30:0] == $past(key_q[31:1])));

    assert_busy_after_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready && in_eop));

    assert_key_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !key_clr && !key_load) |=> (key_q == $past(key_q)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_clr |=> (key_q == 32'd0 && !busy));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && !key_clr) |=> (key_q == $past(key_value) && !busy));

    assert_out_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_no_spurious_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
endmodule

bind pkt_scrambler pkt_scrambler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_clr   (key_clr),
    .key_load  (key_load),
    .key_value (key_value),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .busy      (busy),
    .key_q     (key_q)
);

// File: tb/pkt_scrambler_tb.sv
// Self-checking bench: random packets against a bench-side key model,
// plus directed corner cases.
module pkt_scrambler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_clr = 1'b0;
    logic        key_load = 1'b0;
    logic [31:0] key_value = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_dir = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_sop;
    logic        out_eop;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    pkt_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .key_clr(key_clr), .key_load(key_load),
        .key_value(key_value), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_dir(in_dir),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .busy(busy)
    );

    function automatic logic [31:0] step(input logic [31:0] k);
        logic fb;
        fb = k[0] ^ k[1] ^ k[21] ^ k[31];
        return (k >> 1) | ({31'd0, fb} << 31);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] k, input int idx,
                                            input bit scr, input logic [7:0] d);
        logic [7:0] m;
        m = 8'(k >> ((idx % 4) * 8));
        if (idx == 0 && scr) return (d & 8'h28) | ((d ^ m) & ~8'h28);
        return d ^ m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Send one packet and check every byte and the busy window. 'tag' names the requirement.
    task automatic send_pkt(input int len, input bit scr, input string tag);
        int n;
        int cnt;
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            d = 8'($urandom);
            in_valid = 1'b1; in_data = d; in_dir = scr;
            in_sop = (i == 0); in_eop = (i == len - 1);
            @(negedge clk);
            check(out_valid && out_sop == (i == 0) && out_eop == (i == len - 1),
                  "R10 flags", {out_valid, out_sop, out_eop}, {1'b1, i == 0, i == len - 1});
            check(out_data == exp_byte(model, i, scr, d), tag, out_data, exp_byte(model, i, scr, d));
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        n = int'(model[4:0]) + 35;
        cnt = 0;
        while (busy && cnt < 200) begin
            if (in_ready) begin checks++; fails++; $display("FAIL R9 in_ready high while busy actual=1 expected=0"); end
            cnt++;
            @(negedge clk);
        end
        check(cnt == n, "R2 busy length", cnt, n);
        for (int s = 0; s < n; s++) model = step(model);
    endtask

    task automatic pulse_clr();
        key_clr = 1'b1; @(negedge clk); key_clr = 1'b0; model = '0;
    endtask

    task automatic pulse_load(input logic [31:0] k);
        key_value = k; key_load = 1'b1; @(negedge clk); key_load = 1'b0; model = k;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(in_ready && !busy && !out_valid, "R11 reset state", {in_ready, busy, out_valid}, 3'b100);

        // R7 zero key is transparent, including the scramble direction
        send_pkt(5, 1'b0, "R7 transparent after reset");
        check(model == 32'd0, "R7 zero stays zero", model, 0);
        send_pkt(3, 1'b1, "R7 transparent scramble");

        // R3/R4/R5 with a known key
        pulse_load(32'hA5C3_1F7E);
        send_pkt(9, 1'b1, "R4 scramble byte0 keep 0x28 / R3 lanes");
        pulse_load(32'hFFFF_FFFF);
        send_pkt(6, 1'b0, "R5 descramble full XOR / R3 lanes");
        // R1 via advanced key masking the next packet
        send_pkt(4, 1'b1, "R1 R2 advanced key masks next packet");

        // R9 bytes offered during busy produce nothing
        pulse_load(32'h0000_001F);
        in_valid = 1'b1; in_data = 8'h3C; in_sop = 1'b1; in_eop = 1'b1; in_dir = 1'b0;
        @(negedge clk);
        check(out_data == (8'h3C ^ 8'h1F), "R3 single byte", out_data, 8'h3C ^ 8'h1F);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!out_valid && !in_ready, "R9 held off while busy", {out_valid, in_ready}, 0);
        end
        in_valid = 1'b0;
        // R8 load aborts an advance in progress
        pulse_load(32'h1234_5678);
        check(!busy && in_ready, "R8 load aborts advance", {busy, in_ready}, 2'b01);
        send_pkt(2, 1'b0, "R8 loaded key used");

        // R7 clear aborts an advance, and beats load (R8 priority)
        in_valid = 1'b1; in_data = 8'h00; in_sop = 1'b1; in_eop = 1'b1; in_dir = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        key_value = 32'hDEAD_BEEF; key_load = 1'b1; key_clr = 1'b1;
        @(negedge clk);
        key_load = 1'b0; key_clr = 1'b0; model = '0;
        check(!busy, "R7 clear aborts advance", busy, 0);
        send_pkt(4, 1'b1, "R8 clear beats load, transparent");

        // R6 random traffic with occasional reseed and re-key
        for (int p = 0; p < 60; p++) begin
            int r;
            r = int'($urandom % 10);
            if (r == 0) pulse_clr();
            else if (r == 1) pulse_load($urandom);
            send_pkt(1 + int'($urandom % 9), 1'($urandom), "R6 random packet");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule